// File: doc/BRIEF.md
# Nine-bit SPI shift engine

This block is a full-duplex serial shifter that moves one frame of either 8 or 9 bits at a time. One shift register serves both directions. Each sampling edge pushes the serial input into the least significant end. The serial output always presents the register's outgoing end, which is bit 7 in short frames and bit 8 in long frames. The ninth data bit is written and read through a separate flag beside the 8-bit data word.

The engine can act as clock master or as clock slave. As master it turns a half-period strobe, supplied from outside, into the shift clock that it drives. A master frame starts when software writes the data word. As slave it follows an external clock pin, and the first leading edge starts the frame. In slave mode the clock and data pins pass through three-sample deglitch filters that run on the system clock. A two-bit clock-select field sets the idle level of the clock and chooses which edge samples data. Two static inputs invert the serial input and the serial output. When a frame completes, the block raises a one-cycle completion pulse. While the enable input is low, the block stays in standby.

Top module: `spi9_shift_engine`

## Requirements
- R1: After reset `busy` and `irq` are 0, `rd_data`/`rd_bit8` are 0, and `sck_out` sits at the idle level `sclk_sel[1]`.
- R2: While `enable` is 0, data writes and shift strobes have no effect: `busy` stays 0, `rd_data` keeps its value and `sck_out` stays idle.
- R3: In master mode (`mode_master`=1), a write while idle sets `busy` one cycle later. The clock then toggles once per `shift_tick` and makes exactly 8 periods (`mode_len9`=0) or 9 periods (`mode_len9`=1). Afterwards `sck_out` returns to `sclk_sel[1]`.
- R4: Transmit order is most significant first: bit 8 (`wr_bit8`) then bits 7..0 for 9-bit frames, bits 7..0 for 8-bit frames.
- R5: Received bits enter at bit 0 and move upward. After a frame, `rd_data` holds the last 8 bits received. In 9-bit frames `rd_bit8` holds the first bit received; in 8-bit frames `rd_bit8` keeps its written value.
- R6: A leading edge is a change away from the idle level. With `sclk_sel[0]`=0, input is sampled on leading edges and the output changes on trailing edges. With `sclk_sel[0]`=1 the roles of the two edges are swapped.
- R7: `irq` is a single-cycle pulse after the final trailing edge of a frame, and `busy` is 0 from that cycle on.
- R8: A data write while `busy` is 1 is ignored, and the frame in progress sends its original word.
- R9: In slave mode (`mode_master`=0) the frame is clocked by `sck_in`, starts at its first leading edge, and ends after 8 or 9 periods.
- R10: In slave mode a pin change takes effect only after three consecutive system-clock samples at the new level. A two-sample pulse on `sck_in` is ignored. A leading edge on `sck_in` sets `busy` after the fourth rising `clk` edge that follows it.
- R11: `din_invert`=1 inverts the serial input before it is stored; `dout_invert`=1 inverts `sd_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (oscillator) clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | 1 = active, 0 = standby |
| mode_len9 | input | 1 | 1 = 9-bit frame, 0 = 8-bit frame |
| mode_master | input | 1 | 1 = clock master, 0 = clock slave |
| sclk_sel | input | 2 | [1] idle clock level, [0] 1 = sample on trailing edge |
| din_invert | input | 1 | Invert serial input |
| dout_invert | input | 1 | Invert serial output |
| shift_tick | input | 1 | Master half-period strobe |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | FRAME_W-1 | Data word to send |
| wr_bit8 | input | 1 | Ninth bit to send |
| rd_data | output | FRAME_W-1 | Shift register low bits |
| rd_bit8 | output | 1 | Ninth-bit flag |
| busy | output | 1 | Frame in progress |
| irq | output | 1 | Frame-complete pulse |
| sck_in | input | 1 | External shift clock (slave) |
| sd_in | input | 1 | Serial data input |
| sck_out | output | 1 | Driven shift clock (master) |
| sd_out | output | 1 | Serial data output |

## Verification
The bench builds the engine with its defaults: a long frame of 9 bits and a three-sample filter. With these values a single run reaches both frame lengths, both edge orders and both clock idle levels. It also covers the boundary between a two-sample pulse, which the filter rejects, and a three-sample change, which it accepts, and it checks the exact cycle on which a filtered edge takes effect. Random words and configurations run in master mode against a modelled peer. Directed cases cover standby, writes during a frame and slave-mode frames.

// File: rtl/spi9_pkg.sv
// Shared types for the nine-bit SPI shift engine.
package spi9_pkg;
    // Shift clock event seen by the shift core in one system cycle.
    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_LEAD  = 2'd1,
        EV_TRAIL = 2'd2
    } spi9_edge_e;
endpackage

// File: rtl/spi9_deglitch.sv
// Majority-free run-length filter: the output follows the input only after
// STAGES consecutive samples at the new level. When filt_en is low the
// output simply tracks the input one cycle late.
// Assumes the input is already stable with respect to clk or is tolerant
// of one sample of metastability (the run counter absorbs it).
module spi9_deglitch #(
    parameter int STAGES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic filt_en,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(STAGES + 1);
    localparam logic [CW-1:0] RUN_LAST = CW'(STAGES - 1);

    logic [CW-1:0] run;

    // Count consecutive disagreeing samples and flip on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clean <= 1'b0;
            run   <= '0;
        end else if (!filt_en) begin
            clean <= raw;
            run   <= '0;
        end else if (raw == clean) begin
            run <= '0;
        end else if (run == RUN_LAST) begin
            clean <= raw;
            run   <= '0;
        end else begin
            run <= run + 1'b1;
        end
    end
endmodule

// File: rtl/spi9_sclk_unit.sv
// Shift clock unit. As master it toggles its own clock once per tick while a
// frame is active; as slave it watches the filtered external clock. Either
// way it reports one leading/trailing event per system cycle.
// Assumes cpol and master are static while a frame is active.
module spi9_sclk_unit
    import spi9_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       master,
    input  logic       cpol,
    input  logic       active,
    input  logic       tick,
    input  logic       sck_clean,
    output logic       sck_out,
    output spi9_edge_e edge_ev
);
    logic sck_q;
    logic prev_q;

    // Master clock: park at idle level, toggle on ticks during a frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= cpol;
        end else if (!enable || !active || !master) begin
            sck_q <= cpol;
        end else if (tick) begin
            sck_q <= ~sck_q;
        end
    end

    // Remember the last filtered external clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= sck_clean;
        end
    end

    // Classify this cycle's clock change as leading or trailing.
    always_comb begin
        edge_ev = EV_NONE;
        if (enable) begin
            if (master) begin
                if (active && tick) begin
                    edge_ev = (sck_q == cpol) ? EV_LEAD : EV_TRAIL;
                end
            end else if (sck_clean != prev_q) begin
                edge_ev = (sck_clean != cpol) ? EV_LEAD : EV_TRAIL;
            end
        end
    end

    assign sck_out = master ? sck_q : cpol;
endmodule

// File: rtl/spi9_shift_core.sv
// Shift register, bit counter and completion pulse. Samples on the selected
// edge, launches the next output bit on the other edge, counts trailing
// edges to the frame length. Short frames leave the top bit untouched.
// Assumes len9/cpha/master are static while a frame is active.
module spi9_shift_core
    import spi9_pkg::*;
#(
    parameter int FRAME_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               len9,
    input  logic               master,
    input  logic               cpha,
    input  spi9_edge_e         edge_ev,
    input  logic               din,
    input  logic               wr_en,
    input  logic [FRAME_W-1:0] wr_word,
    output logic [FRAME_W-1:0] word,
    output logic               tx_bit,
    output logic               active,
    output logic               irq
);
    localparam int CNT_W = $clog2(FRAME_W + 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(FRAME_W - 2);

    logic [CNT_W-1:0]   cnt;
    logic [CNT_W-1:0]   last;
    logic [FRAME_W-1:0] shifted;
    logic               msb, starting, live, is_sample, is_launch, load;

    // Decode frame length, outgoing bit and the edge roles for this cycle.
    always_comb begin
        last      = len9 ? LAST_LONG : LAST_SHORT;
        msb       = len9 ? word[FRAME_W-1] : word[FRAME_W-2];
        shifted   = len9 ? {word[FRAME_W-2:0], din}
                         : {word[FRAME_W-1], word[FRAME_W-3:0], din};
        starting  = !active && !master && (edge_ev == EV_LEAD);
        live      = active || starting;
        is_sample = live && (cpha ? (edge_ev == EV_TRAIL) : (edge_ev == EV_LEAD));
        is_launch = live && (cpha ? (edge_ev == EV_LEAD)
                                  : ((edge_ev == EV_TRAIL) && (cnt != last)));
        load      = enable && wr_en && !live;
    end

    // Frame sequencing: load, shift, launch, count and completion pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word   <= '0;
            tx_bit <= 1'b0;
            active <= 1'b0;
            cnt    <= '0;
            irq    <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (!enable) begin
                active <= 1'b0;
                cnt    <= '0;
            end else if (load) begin
                word   <= wr_word;
                tx_bit <= len9 ? wr_word[FRAME_W-1] : wr_word[FRAME_W-2];
                active <= master;
                cnt    <= '0;
            end else begin
                if (starting) begin
                    active <= 1'b1;
                end
                if (is_sample) begin
                    word <= shifted;
                end
                if (is_launch) begin
                    tx_bit <= msb;
                end
                if (live && (edge_ev == EV_TRAIL)) begin
                    if (cnt == last) begin
                        active <= 1'b0;
                        cnt    <= '0;
                        irq    <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/spi9_shift_engine.sv
// Top of the nine-bit SPI shift engine: pin polarity, slave-mode input
// filters, the shift clock unit and the shift core.
// Assumes the configuration inputs change only while busy is low.
module spi9_shift_engine
    import spi9_pkg::*;
#(
    parameter int FRAME_W  = 9,
    parameter int GLITCH_N = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               mode_len9,
    input  logic               mode_master,
    input  logic [1:0]         sclk_sel,
    input  logic               din_invert,
    input  logic               dout_invert,
    input  logic               shift_tick,
    input  logic               wr_en,
    input  logic [FRAME_W-2:0] wr_data,
    input  logic               wr_bit8,
    output logic [FRAME_W-2:0] rd_data,
    output logic               rd_bit8,
    output logic               busy,
    output logic               irq,
    input  logic               sck_in,
    input  logic               sd_in,
    output logic               sck_out,
    output logic               sd_out
);
    logic               din_pin, din_clean, sck_clean, core_din, tx_bit, active;
    logic [FRAME_W-1:0] word;
    spi9_edge_e         edge_ev;

    assign din_pin = sd_in ^ din_invert;

    spi9_deglitch #(.STAGES(GLITCH_N)) u_dg_data (
        .clk(clk), .rst_n(rst_n), .filt_en(!mode_master),
        .raw(din_pin), .clean(din_clean)
    );

    spi9_deglitch #(.STAGES(GLITCH_N)) u_dg_clk (
        .clk(clk), .rst_n(rst_n), .filt_en(!mode_master),
        .raw(sck_in), .clean(sck_clean)
    );

    spi9_sclk_unit u_sclk (
        .clk(clk), .rst_n(rst_n), .enable(enable), .master(mode_master),
        .cpol(sclk_sel[1]), .active(active), .tick(shift_tick),
        .sck_clean(sck_clean), .sck_out(sck_out), .edge_ev(edge_ev)
    );

    assign core_din = mode_master ? din_pin : din_clean;

    spi9_shift_core #(.FRAME_W(FRAME_W)) u_core (
        .clk(clk), .rst_n(rst_n), .enable(enable), .len9(mode_len9),
        .master(mode_master), .cpha(sclk_sel[0]), .edge_ev(edge_ev),
        .din(core_din), .wr_en(wr_en), .wr_word({wr_bit8, wr_data}),
        .word(word), .tx_bit(tx_bit), .active(active), .irq(irq)
    );

    assign rd_data = word[FRAME_W-2:0];
    assign rd_bit8 = word[FRAME_W-1];
    assign busy    = active;
    assign sd_out  = tx_bit ^ dout_invert;
endmodule

// File: rtl/spi9_shift_engine_chk.sv
// Port-level temporal checks for spi9_shift_engine, bound to every instance.
module spi9_shift_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       enable,
    input logic       mode_master,
    input logic [1:0] sclk_sel,
    input logic       dout_invert,
    input logic       shift_tick,
    input logic       busy,
    input logic       irq,
    input logic       sck_out,
    input logic       sd_out
);
    // R7: completion pulse lasts one cycle.
    p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R7: busy is already low when the pulse appears.
    p_irq_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (!busy && $past(busy)));

    // R2: standby never starts a frame.
    p_standby_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!busy && !irq));

    // R3: master clock rests at its idle level between frames.
    p_idle_clock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && !busy && !$past(busy) && $stable(sclk_sel))
        |-> (sck_out == sclk_sel[1]));

    // R6: without a tick nothing on the master pins moves.
    p_master_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_master && busy && !shift_tick && enable)
        |=> ($stable(sck_out) && ($stable(sd_out) || !$stable(dout_invert))));
endmodule

bind spi9_shift_engine spi9_shift_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_master(mode_master),
    .sclk_sel(sclk_sel), .dout_invert(dout_invert), .shift_tick(shift_tick),
    .busy(busy), .irq(irq), .sck_out(sck_out), .sd_out(sd_out)
);

// File: tb/spi9_shift_engine_tb.sv
module spi9_shift_engine_tb;
    logic       clk = 1'b0;
    logic       rst_n, enable, mode_len9, mode_master, din_invert, dout_invert;
    logic [1:0] sclk_sel;
    logic       shift_tick, wr_en, wr_bit8, sck_in, sd_in;
    logic [7:0] wr_data, rd_data;
    logic       rd_bit8, busy, irq, sck_out, sd_out;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;

    // Bench-side peer state, owned by the monitor except where noted.
    logic       tick_en = 0, mon_en = 0, mon_clr = 0, sd_m = 0, sd_s = 0;
    int         tph = 0, rx_k = 0, lead_seen = 0, irq_seen = 0, plen = 8;
    logic [8:0] pw = '0;
    logic       cur_cpol = 0, cur_cpha = 0, prev_sck = 0;
    logic       rec [0:8];
    logic       rec_s [0:8];

    always #10 clk = ~clk;

    assign sd_in = mon_en ? sd_m : sd_s;

    spi9_shift_engine u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .mode_len9(mode_len9),
        .mode_master(mode_master), .sclk_sel(sclk_sel), .din_invert(din_invert),
        .dout_invert(dout_invert), .shift_tick(shift_tick), .wr_en(wr_en),
        .wr_data(wr_data), .wr_bit8(wr_bit8), .rd_data(rd_data), .rd_bit8(rd_bit8),
        .busy(busy), .irq(irq), .sck_in(sck_in), .sd_in(sd_in),
        .sck_out(sck_out), .sd_out(sd_out)
    );

    function automatic logic peer_bit(input int k);
        return (k < plen) ? pw[plen-1-k] : 1'b0;
    endfunction

    // Expected transmit word as seen MSB first, len bits wide.
    function automatic logic [8:0] exp_tx(input logic l9, input logic [8:0] w);
        return l9 ? w : {1'b0, w[7:0]};
    endfunction

    // Tick generator: one strobe every third cycle.
    always @(negedge clk) begin
        if (tick_en) begin
            shift_tick <= (tph == 0);
            tph <= (tph == 2) ? 0 : tph + 1;
        end else begin
            shift_tick <= 1'b0;
            tph <= 0;
        end
    end

    // Master peer model: record output and change input on sampling edges.
    always @(negedge clk) begin
        if (mon_clr) begin
            rx_k = 0; lead_seen = 0; irq_seen = 0;
            sd_m = pw[plen-1] ^ din_invert;
        end else begin
            if (irq) irq_seen++;
            if (mon_en && (sck_out !== prev_sck)) begin
                if (sck_out != cur_cpol) lead_seen++;
                if ((sck_out != cur_cpol) != cur_cpha) begin
                    if (rx_k < 9) rec[rx_k] = sd_out ^ dout_invert;
                    rx_k++;
                    sd_m = peer_bit(rx_k) ^ din_invert;
                end
            end
        end
        prev_sck = sck_out;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_mon();
        @(posedge clk); mon_clr = 1;
        @(posedge clk); mon_clr = 0;
    endtask

    task automatic write_word(input logic [8:0] w);
        @(negedge clk); wr_en = 1; wr_data = w[7:0]; wr_bit8 = w[8];
        @(negedge clk); wr_en = 0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 600 && busy; i++) @(negedge clk);
    endtask

    task automatic end_checks(input string m, input logic l9, input logic [8:0] tx,
                              input logic [8:0] peer, input logic [8:0] got);
        logic [8:0] e_rx;
        e_rx = l9 ? peer : {tx[8], peer[7:0]};
        chk(got == exp_tx(l9, tx), {"R4 tx order ", m}, got, exp_tx(l9, tx));
        chk(rd_data == e_rx[7:0], {"R5 rx data ", m}, rd_data, e_rx[7:0]);
        chk(rd_bit8 == e_rx[8], {"R5 bit8 flag ", m}, rd_bit8, e_rx[8]);
        chk(irq_seen == 1, {"R7 one irq cycle ", m}, irq_seen, 1);
        chk(!busy, {"R7 busy cleared ", m}, busy, 0);
    endtask

    task automatic master_frame(input logic l9, input logic cpha, input logic cpol,
                                input logic di, input logic dq, input logic [8:0] tx,
                                input logic [8:0] peer, input bit intrude);
        logic [8:0] got;
        @(negedge clk);
        mode_master = 1; mode_len9 = l9; sclk_sel = {cpol, cpha};
        din_invert = di; dout_invert = dq;
        cur_cpol = cpol; cur_cpha = cpha; pw = peer; plen = l9 ? 9 : 8;
        waitn(4);
        mon_en = 1;
        clear_mon();
        write_word(tx);
        chk(busy == 1, "R3 busy after write", busy, 1);
        tick_en = 1;
        if (intrude) begin
            waitn(10);
            write_word(~tx);
        end
        wait_idle();
        waitn(3);
        tick_en = 0;
        mon_en = 0;
        got = '0;
        for (int i = 0; i < plen; i++) got = {got[7:0], rec[i]};
        chk(lead_seen == plen, "R3 clock periods", lead_seen, plen);
        chk(sck_out == cpol, "R3 clock idle after frame", sck_out, cpol);
        chk(rx_k == plen, "R6 sampling edges", rx_k, plen);
        end_checks(intrude ? "R8 busy write" : (di | dq) ? "R11 inv" : "master",
                   l9, tx, peer, got);
    endtask

    task automatic slave_edge(input logic lvl, input bit chk_delay);
        sck_in = lvl;
        if (chk_delay) begin
            repeat (3) @(posedge clk);
            @(negedge clk);
            chk(busy == 0, "R10 no start before third sample", busy, 0);
            @(posedge clk);
            @(negedge clk);
            chk(busy == 1, "R10 start after filter delay", busy, 1);
            waitn(4);
        end else begin
            waitn(8);
        end
    endtask

    task automatic slave_frame(input logic l9, input logic cpha, input logic cpol,
                               input logic di, input logic dq, input logic [8:0] tx,
                               input logic [8:0] peer, input bit chk_delay);
        logic [8:0] got;
        int len;
        len = l9 ? 9 : 8;
        @(negedge clk);
        mode_master = 0; mode_len9 = l9; sclk_sel = {cpol, cpha};
        din_invert = di; dout_invert = dq; sck_in = cpol; sd_s = 0;
        pw = peer; plen = len;
        waitn(10);
        clear_mon();
        write_word(tx);
        waitn(2);
        for (int i = 0; i < len; i++) begin
            if (!cpha) begin
                sd_s = peer[len-1-i] ^ di;
                waitn(8);
                slave_edge(~cpol, chk_delay && i == 0);
                rec_s[i] = sd_out ^ dq;
                sck_in = cpol;
                waitn(8);
            end else begin
                slave_edge(~cpol, chk_delay && i == 0);
                sd_s = peer[len-1-i] ^ di;
                rec_s[i] = sd_out ^ dq;
                waitn(8);
                sck_in = cpol;
                waitn(8);
            end
        end
        waitn(4);
        got = '0;
        for (int i = 0; i < len; i++) got = {got[7:0], rec_s[i]};
        end_checks("R9 slave", l9, tx, peer, got);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        rst_n = 0; enable = 0; mode_len9 = 0; mode_master = 1; sclk_sel = 2'b00;
        din_invert = 0; dout_invert = 0; wr_en = 0; wr_data = 0; wr_bit8 = 0;
        sck_in = 0;
        waitn(4);
        rst_n = 1;
        waitn(2);
        // R1 reset state
        chk(busy == 0, "R1 busy", busy, 0);
        chk(irq == 0, "R1 irq", irq, 0);
        chk({rd_bit8, rd_data} == 9'h0, "R1 data", {rd_bit8, rd_data}, 0);
        chk(sck_out == 0, "R1 clock idle", sck_out, 0);

        // R2 standby: write and ticks ignored
        write_word(9'h1A5);
        tick_en = 1;
        waitn(30);
        chk(busy == 0, "R2 standby busy", busy, 0);
        chk({rd_bit8, rd_data} == 9'h0, "R2 standby data", {rd_bit8, rd_data}, 0);
        chk(sck_out == 0, "R2 standby clock", sck_out, 0);
        tick_en = 0;
        enable = 1;

        // Directed master frames: all edge/idle combos, both lengths
        master_frame(1, 0, 0, 0, 0, 9'h1C3, 9'h0A5, 0);
        master_frame(0, 1, 1, 0, 0, 9'h15A, 9'h13C, 0);
        master_frame(1, 1, 0, 1, 1, 9'h0F0, 9'h1E1, 0);
        master_frame(0, 0, 1, 0, 0, 9'h081, 9'h17E, 1);
        master_frame(1, 0, 1, 0, 0, 9'h155, 9'h0AA, 1);

        // Random master frames
        for (int n = 0; n < 20; n++) begin
            master_frame($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                         $urandom % 2, 9'($urandom), 9'($urandom), 0);
        end

        // R10 glitch rejection in slave mode
        @(negedge clk);
        mode_master = 0; sclk_sel = 2'b00; sck_in = 0;
        waitn(10);
        for (int g = 0; g < 3; g++) begin
            sck_in = 1;
            repeat (2) @(posedge clk);
            @(negedge clk);
            sck_in = 0;
            waitn(6);
        end
        chk(busy == 0, "R10 two-sample pulse ignored", busy, 0);

        // Slave frames
        slave_frame(1, 0, 0, 0, 0, 9'h12D, 9'h0B4, 1);
        slave_frame(0, 1, 1, 1, 0, 9'h0C6, 9'h139, 1);
        slave_frame(1, 1, 0, 0, 1, 9'h0FF, 9'h100, 0);
        slave_frame(0, 0, 1, 0, 0, 9'h1E7, 9'h018, 0);
        for (int n = 0; n < 4; n++) begin
            slave_frame($urandom % 2, $urandom % 2, $urandom % 2, $urandom % 2,
                        $urandom % 2, 9'($urandom), 9'($urandom), 0);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule